// File: doc/BRIEF.md
# Sliced Pipelined Unsigned Multiplier

This block multiplies two unsigned 8-bit operands into a full 16-bit product using general logic only. Each operand is cut into slices no wider than a slice-width parameter. Every slice of one operand is multiplied by every slice of the other, and the small products are recombined by shifting and adding. Registers sit between the arithmetic stages: the small products, then the per-row sums, then the final sum. This shortens the longest combinational path instead of simply adding delay before or after one large multiplier.

A caller presents an operand pair with a valid strobe on any cycle. The result appears three cycles later with its own valid strobe. A new pair may be accepted every cycle. When the slice width is at least the operand width, each operand is a single slice and one plain multiply is formed. The three-stage timing stays the same.

Top module: `part_pipe_mul`

## Requirements
- R1: Whenever `prodValid` is high, `prod` equals the exact unsigned product of the operand pair that was accepted with it, with nothing truncated (for example 255 x 255 = 65025).
- R2: A pair whose `opValid` is high at rising edge k makes `prodValid` high after rising edge k+2. Both operands and the product are then visible during the third cycle after they are driven.
- R3: Pairs presented on consecutive cycles produce results on consecutive cycles, in the same order, with no pair lost.
- R4: `prodValid` is low in every output cycle whose matching input cycle had `opValid` low.
- R5: While `rst` is high at a rising edge, every stage valid is cleared. `prodValid` is low after that edge, and `prod` reads 0 until a valid result arrives.
- R6: With `SLICE_W` at or above `OP_W` (for example `SLICE_W` = 8), no splitting occurs. The results and timing are identical to R1 and R2.
- R7: With a slice width that does not divide the operand width (for example `SLICE_W` = 3, giving three slices zero-extended to 9 bits), the results and timing are identical to R1 and R2.
- R8: While `prodValid` is low, `prod` holds the last valid product, or 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | OP_W | First unsigned operand |
| opB | input | OP_W | Second unsigned operand |
| opValid | input | 1 | Operand pair is valid this cycle |
| prod | output | 2*OP_W | Registered product |
| prodValid | output | 1 | Product is valid this cycle |

## Verification
A wrong small product, a wrong shift weight or a wrong row sum appears as a wrong `prod` exactly three cycles after the offending pair. Because every pair of operands is swept, a bad slice boundary cannot hide behind a narrow set of values. A broken valid chain shows as `prodValid` arriving one cycle early or late, or as a lost bubble. This is visible on the first pair after reset and on every gap. A data register that fails to hold appears as a changed `prod` during a bubble in the same cycle.

// File: rtl/part_pipe_mul_pkg.sv
package part_pipe_mul_pkg;
  // Stage load strobes handed from control to datapath
  typedef struct packed {
    logic ldPart;   // capture slice products
    logic ldRow;    // capture row sums
    logic ldSum;    // capture final sum
  } stage_strobe_t;
endpackage

// File: rtl/part_pipe_mul_ctrl.sv
module part_pipe_mul_ctrl
  import part_pipe_mul_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          opValid,
  output stage_strobe_t strb,
  output logic          prodValid
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] stgValid;

  always_ff @(posedge clk) begin
    if (rst) stgValid <= '0;
    else     stgValid <= {stgValid[STAGES-2:0], opValid};
  end

  always_comb begin
    strb.ldPart = opValid;
    strb.ldRow  = stgValid[0];
    strb.ldSum  = stgValid[1];
  end

  assign prodValid = stgValid[STAGES-1];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (stgValid == '0)); // R5

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    opValid |=> ##2 prodValid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> ##2 !prodValid); // R4
endmodule

// File: rtl/part_pipe_mul_dp.sv
module part_pipe_mul_dp
  import part_pipe_mul_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  stage_strobe_t     strb,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] prod
);
  localparam int PART_W = (SLICE_W < OP_W) ? SLICE_W : OP_W;
  localparam int NSL    = (OP_W + PART_W - 1) / PART_W;
  localparam int EXT_W  = NSL * PART_W;
  localparam int PP_W   = 2 * PART_W;
  localparam int ROW_W  = PART_W + EXT_W;
  localparam int ACC_W  = ROW_W + EXT_W;
  localparam int PROD_W = 2 * OP_W;

  logic [EXT_W-1:0] aExt, bExt;
  assign aExt = EXT_W'(opA);
  assign bExt = EXT_W'(opB);

  logic [PP_W-1:0]  ppQ  [NSL][NSL];
  logic [ROW_W-1:0] rowD [NSL];
  logic [ROW_W-1:0] rowQ [NSL];
  logic [ACC_W-1:0] sumD;

  // Stage 1: slice products
  for (genvar gi = 0; gi < NSL; gi++) begin : g_row
    for (genvar gj = 0; gj < NSL; gj++) begin : g_col
      always_ff @(posedge clk) begin
        if (rst)
          ppQ[gi][gj] <= '0;
        else if (strb.ldPart)
          ppQ[gi][gj] <= PP_W'(aExt[gi*PART_W +: PART_W]) *
                         PP_W'(bExt[gj*PART_W +: PART_W]);
      end
    end
  end

  // Stage 2: per-row shifted sums
  always_comb begin
    for (int i = 0; i < NSL; i++) begin
      rowD[i] = '0;
      for (int j = 0; j < NSL; j++)
        rowD[i] = rowD[i] + (ROW_W'(ppQ[i][j]) << (j * PART_W));
    end
  end

  for (genvar gr = 0; gr < NSL; gr++) begin : g_rowreg
    always_ff @(posedge clk) begin
      if (rst)            rowQ[gr] <= '0;
      else if (strb.ldRow) rowQ[gr] <= rowD[gr];
    end
  end

  // Stage 3: rows weighted and summed
  always_comb begin
    sumD = '0;
    for (int i = 0; i < NSL; i++)
      sumD = sumD + (ACC_W'(rowQ[i]) << (i * PART_W));
  end

  always_ff @(posedge clk) begin
    if (rst)             prod <= '0;
    else if (strb.ldSum) prod <= sumD[PROD_W-1:0];
  end

  AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    strb.ldPart |=> ##2 (prod == $past(PROD_W'(opA) * PROD_W'(opB), 3))); // R1

  AST_HOLD_PROD: assert property (@(posedge clk) disable iff (rst)
    !strb.ldSum |=> $stable(prod)); // R8
endmodule

// File: rtl/part_pipe_mul.sv
module part_pipe_mul
  import part_pipe_mul_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              opValid,
  output logic [2*OP_W-1:0] prod,
  output logic              prodValid
);
  stage_strobe_t strb;

  part_pipe_mul_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opValid   (opValid),
    .strb      (strb),
    .prodValid (prodValid)
  );

  part_pipe_mul_dp #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_dp (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .opA  (opA),
    .opB  (opB),
    .prod (prod)
  );
endmodule

// File: tb/part_pipe_mul_bench.sv
module part_pipe_mul_bench;
  localparam int OP_W = 8;
  localparam int PW   = 2 * OP_W;

  typedef struct { bit v; int p; } slot_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [OP_W-1:0] opA = '0, opB = '0;
  logic          opValid = 1'b0;
  logic [PW-1:0] prodN, prodW, prodO;
  logic          vldN, vldW, vldO;

  int checks = 0, fails = 0, cycles = 0;
  slot_t q[$];
  int holdExp = 0;
  bit expV;

  always #4 clk = ~clk; // 125 MHz

  part_pipe_mul #(.OP_W(OP_W), .SLICE_W(4)) u_part_pipe_mul (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opValid(opValid),
    .prod(prodN), .prodValid(vldN));
  part_pipe_mul #(.OP_W(OP_W), .SLICE_W(8)) u_part_pipe_mul_whole (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opValid(opValid),
    .prod(prodW), .prodValid(vldW));
  part_pipe_mul #(.OP_W(OP_W), .SLICE_W(3)) u_part_pipe_mul_odd (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opValid(opValid),
    .prod(prodO), .prodValid(vldO));

  // Behavioural reference: 3-deep delay of (valid, a*b) plus last-held product
  always @(posedge clk) begin
    slot_t s;
    cycles++;
    if (rst) begin
      q.delete();
      for (int i = 0; i < 3; i++) q.push_back('{v: 1'b0, p: 0});
      holdExp = 0;
    end else begin
      s.v = opValid;
      s.p = int'(opA) * int'(opB);
      q.push_back(s);
      void'(q.pop_front());
      if (q[0].v) holdExp = q[0].p;
    end
    expV = q[0].v;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cmpAll();
    chk("R2/R4 valid SLICE4", int'(vldN), int'(expV));
    chk("R6 valid SLICE8",    int'(vldW), int'(expV));
    chk("R7 valid SLICE3",    int'(vldO), int'(expV));
    chk(expV ? "R1 prod SLICE4" : "R8 hold SLICE4", int'(prodN), holdExp);
    chk(expV ? "R6 prod SLICE8" : "R8 hold SLICE8", int'(prodW), holdExp);
    chk(expV ? "R7 prod SLICE3" : "R8 hold SLICE3", int'(prodO), holdExp);
  endtask

  // Compare on every cycle, away from the active edge
  always @(negedge clk) if (cycles > 0) cmpAll();

  task automatic drive(input int a, input int b, input bit v);
    @(negedge clk);
    opA = OP_W'(a); opB = OP_W'(b); opValid = v;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset valid", int'(vldN), 0);
    chk("R5 reset prod",  int'(prodN), 0);
    @(negedge clk); rst = 1'b0;
    // R1 corners, R3 back-to-back
    drive(255, 255, 1);
    drive(0, 0, 1);
    drive(255, 1, 1);
    drive(128, 2, 1);
    drive(15, 16, 1);
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 last corner held 15*16", int'(prodN), 240);
    drive(255, 255, 1);
    drive(0, 0, 0);
    @(negedge clk); @(negedge clk);
    chk("R1 255*255 full width", int'(prodN), 65025);
    // R4 gaps, R8 hold
    drive(3, 7, 1); drive(9, 9, 0); drive(5, 5, 0); drive(2, 200, 1);
    drive(77, 77, 0); drive(1, 1, 0); drive(1, 1, 0);
    // exhaustive sweep with a bubble every 7th cycle (R1, R3, R6, R7)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive(a, b, ((a * 256 + b) % 7) != 6);
    // R5: reset in mid-stream drops in-flight pairs
    drive(200, 100, 1);
    @(negedge clk); rst = 1'b1; opValid = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R5 mid-stream reset valid", int'(vldN), 0);
    chk("R5 mid-stream reset prod",  int'(prodN), 0);
    drive(13, 11, 1);
    drive(0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R8 hold after drain", int'(prodN), 143);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule